// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block is a synchronous controller for an external asynchronous static RAM of 64K words by 32 bits. A host issues one single-word read or write at a time over a valid/ready handshake. Each request carries an address, write data and a byte-lane mask. The controller turns the request into a timed sequence on the memory pins. It drives one active-low chip enable per byte lane, an active-low write strobe and an active-low output enable. It also drives the data-bus output and its drive-enable. For a read it returns the captured word with a one-cycle valid strobe.

Masked accesses use the per-lane enables: only the lanes selected in the mask are enabled on the memory. Every memory timing limit is a nanosecond parameter. A clock-period parameter turns each limit into a cycle count, rounding up.

The sequencer is a single state machine with six states:
- `S_IDLE`: accepts a request.
- `S_WR_SETUP`, `S_WR_PULSE`, `S_WR_HOLD`: the three phases of a write.
- `S_RD_ACCESS`: the read access window.
- `S_RD_TURN`: the bus turnaround after a read.

Its transitions are:
- `S_IDLE` goes to `S_WR_SETUP` when a write is accepted, and to `S_RD_ACCESS` when a read is accepted.
- `S_WR_SETUP` goes to `S_WR_PULSE`, then `S_WR_PULSE` goes to `S_WR_HOLD`, then `S_WR_HOLD` returns to `S_IDLE`.
- `S_RD_ACCESS` goes to `S_RD_TURN`, then `S_RD_TURN` returns to `S_IDLE`.

Each state is left when its cycle counter reaches its last cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While in reset and while idle, all four lane enables, the write strobe and the output enable are high (1), the bus drive-enable is 0, and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the access is over, and request inputs changed during that time have no effect on the memory pins.
- R3: A write first spends SETUP cycles in `S_WR_SETUP`. During these cycles the address is presented, the write strobe is high, and `mem_ce_n[i]` is 0 exactly for the lanes whose mask bit `i` is 1. Lane `i` is data bits 8i+7..8i.
- R4: The write strobe is then low for PULSE cycles, and the bus carries the write data with drive-enable 1. The bus is driven only in `S_WR_PULSE` and `S_WR_HOLD`.
- R5: After the write strobe rises, the address, lane enables and write data stay unchanged and driven for HOLD cycles before the controller returns to idle.
- R6: The output enable stays high for the whole of every write.
- R7: A read holds the selected lane enables low, the output enable low and the write strobe high for READ cycles, with the bus not driven.
- R8: The read word is sampled on the last access cycle. It appears on `rd_data` together with a one-cycle `rd_valid` pulse in the first cycle after the access window. Lanes whose mask bit is 0 read as zero.
- R9: After a read, the controller spends TURN cycles in `S_RD_TURN` with every enable high and the bus released before it accepts a new request.
- R10: Each limit converts to cycles as ceil(ns / CLK_NS), and 0 ns gives 0. The phase lengths are derived as follows: SETUP = max(1, t_as); HOLD = max(1, t_wr, t_dh); PULSE = max(1, t_wp, t_dw, t_wc − SETUP − HOLD); READ = max(1, t_aa, t_oe); TURN = max(1, t_ohz). With the default parameters these give 1, 1, 1, 2 and 1 cycles.
- R11: A request with mask 0 enables no lane, changes no memory word, and returns zero on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| req_lanes | input | 4 | Byte-lane mask, bit i selects data bits 8i+7..8i |
| rd_data | output | 32 | Captured read word, unselected lanes zero |
| rd_valid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 4 | Active-low per-lane chip enables |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_o | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Data-bus drive enable |
| mem_dq_i | input | 32 | Data returned from memory |

## Verification
With the default timing, a write taken at edge N is in its setup phase after N, in its strobe phase after N+1 and in its hold phase after N+2, and the controller is idle after N+3. A read taken at edge N drives the output enable low after N and after N+1. Its word and `rd_valid` are due after edge N+2, and the controller is idle after N+3. The bench drives and samples at falling edges, and it checks the memory pins in each of these cycles against the expected phase. A sweep writes every lane mask to several addresses and reads each word back in full and under every mask. Expected words come from a shadow array that the bench merges arithmetically.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WR_HOLD,
        S_RD_ACCESS,
        S_RD_TURN
    } ctrl_state_e;

    // Round a nanosecond limit up to whole clock cycles; zero stays zero.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic [LANES-1:0]   lanes,
    input  logic [8*LANES-1:0] dq_in,
    output logic [8*LANES-1:0] data,
    output logic               valid
);
    logic [8*LANES-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[8*g +: 8] = lanes[g] ? dq_in[8*g +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= cap;
            if (cap) data <= masked;
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int CLK_NS   = 20,
    parameter int T_AS_NS  = 2,
    parameter int T_WP_NS  = 20,
    parameter int T_DW_NS  = 15,
    parameter int T_WC_NS  = 25,
    parameter int T_WR_NS  = 2,
    parameter int T_DH_NS  = 3,
    parameter int T_AA_NS  = 25,
    parameter int T_OE_NS  = 15,
    parameter int T_OHZ_NS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_lanes,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i
);
    localparam int LANES   = DATA_W / 8;
    localparam int SETUP_C = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
    localparam int HOLD_C  = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_NS),
                                          ns_to_cyc(T_DH_NS, CLK_NS)));
    localparam int PULSE_C = imax(imax(1, ns_to_cyc(T_WP_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_DW_NS, CLK_NS),
                                       ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_C - HOLD_C));
    localparam int READ_C  = imax(1, imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                          ns_to_cyc(T_OE_NS, CLK_NS)));
    localparam int TURN_C  = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));
    localparam int MAX_C   = imax(imax(SETUP_C, HOLD_C),
                                  imax(PULSE_C, imax(READ_C, TURN_C)));
    localparam int CNT_W   = $clog2(MAX_C + 1);

    ctrl_state_e         state_q, state_nx;
    logic                last;
    logic                tm_load;
    logic [CNT_W-1:0]    tm_val;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    lanes_q;
    logic                accept;
    logic                cap;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_nx;
    end

    // Request latch, loaded only on acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            lanes_q <= req_lanes;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_nx = req_write ? S_WR_SETUP : S_RD_ACCESS;
            S_WR_SETUP:  if (last) state_nx = S_WR_PULSE;
            S_WR_PULSE:  if (last) state_nx = S_WR_HOLD;
            S_WR_HOLD:   if (last) state_nx = S_IDLE;
            S_RD_ACCESS: if (last) state_nx = S_RD_TURN;
            S_RD_TURN:   if (last) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // Phase length loaded on every state change
    always_comb begin
        tm_load = (state_nx != state_q);
        tm_val  = '0;
        unique case (state_nx)
            S_WR_SETUP:  tm_val = CNT_W'(SETUP_C - 1);
            S_WR_PULSE:  tm_val = CNT_W'(PULSE_C - 1);
            S_WR_HOLD:   tm_val = CNT_W'(HOLD_C - 1);
            S_RD_ACCESS: tm_val = CNT_W'(READ_C - 1);
            S_RD_TURN:   tm_val = CNT_W'(TURN_C - 1);
            default:     tm_val = '0;
        endcase
    end

    // Pin outputs
    always_comb begin
        mem_ce_n  = '1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            S_WR_SETUP: mem_ce_n = ~lanes_q;
            S_WR_PULSE: begin
                mem_ce_n  = ~lanes_q;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            S_WR_HOLD: begin
                mem_ce_n  = ~lanes_q;
                mem_dq_oe = 1'b1;
            end
            S_RD_ACCESS: begin
                mem_ce_n = ~lanes_q;
                mem_oe_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign cap      = (state_q == S_RD_ACCESS) && last;

    sram_cyc_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .last     (last)
    );

    sram_rd_capture #(.LANES(LANES)) u_cap (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .lanes (lanes_q),
        .dq_in (mem_dq_i),
        .data  (rd_data),
        .valid (rd_valid)
    );
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [DATA_W/8-1:0] req_lanes,
    input logic [DATA_W-1:0]   rd_data,
    input logic                rd_valid,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_ce_n,
    input logic                mem_we_n,
    input logic                mem_oe_n,
    input logic [DATA_W-1:0]   mem_dq_o,
    input logic                mem_dq_oe,
    input logic [DATA_W-1:0]   mem_dq_i
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_ce_n) && mem_we_n && mem_oe_n && !mem_dq_oe);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_we_fall_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(mem_ce_n) == mem_ce_n) && !(&mem_ce_n || 1'b0) || (&mem_ce_n));

    p_drive_no_oe_r4: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    p_hold_after_we_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe && $stable(mem_addr) && $stable(mem_ce_n) && $stable(mem_dq_o));

    p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    p_valid_follows_read_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_oe_n));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_turn_released_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (&mem_ce_n) && !mem_dq_oe && !req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_lanes = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [15:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_i;

    int vectors = 0;
    int errs = 0;
    bit done = 0;

    logic [31:0] model  [256];
    logic [31:0] shadow [256];

    always #10 clk = ~clk;

    sram_lane_ctrl u0 (.*);

    // Memory chip model: lanes respond only when enabled.
    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_dq_i[8*i +: 8] = (!mem_ce_n[i] && !mem_oe_n && mem_we_n) ?
                                 model[mem_addr[7:0]][8*i +: 8] : 8'h5A;
    end

    always @(posedge mem_we_n) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++)
                if (!mem_ce_n[i]) model[mem_addr[7:0]][8*i +: 8] <= mem_dq_o[8*i +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = m[i] ? d[8*i +: 8] : 8'h00;
        return r;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = m[i] ? d[8*i +: 8] : old[8*i +: 8];
        return r;
    endfunction

    // Default timing: setup 1, pulse 1, hold 1 cycles (R10).
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_lanes = m;
        @(negedge clk);
        chk(mem_we_n && mem_oe_n && mem_ce_n == ~m && !mem_dq_oe && mem_addr == a,
            "R3 setup", {mem_ce_n, 3'b0, mem_we_n, 3'b0, mem_oe_n, mem_addr}, {~m, 8'h11, a});
        chk(!req_ready, "R2 busy", 32'(req_ready), 0);
        req_addr = ~a; req_wdata = ~d; req_lanes = ~m; req_write = 0;
        @(negedge clk);
        chk(!mem_we_n && mem_dq_oe && mem_dq_o == d && mem_ce_n == ~m,
            "R4 pulse", mem_dq_o, d);
        chk(mem_oe_n, "R6 oe high", 32'(mem_oe_n), 1);
        chk(mem_addr == a, "R2 ignored", 32'(mem_addr), 32'(a));
        @(negedge clk);
        chk(mem_we_n && mem_dq_oe && mem_dq_o == d && mem_addr == a && mem_ce_n == ~m,
            "R5 hold", {mem_dq_oe, mem_addr, 11'b0, mem_ce_n}, {1'b1, a, 11'b0, ~m});
        req_valid = 0;
        @(negedge clk);
        chk(req_ready && &mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 idle after write", {mem_ce_n, 28'(req_ready)}, {4'hF, 28'd1});
        shadow[a[7:0]] = merge(shadow[a[7:0]], d, m);
    endtask

    // Default timing: read 2 cycles, turn 1 cycle (R10).
    task automatic do_read(input logic [15:0] a, input logic [3:0] m);
        logic [31:0] exp;
        exp = lane_mask(shadow[a[7:0]], m);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_lanes = m;
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            chk(!mem_oe_n && mem_we_n && mem_ce_n == ~m && !mem_dq_oe && mem_addr == a && !rd_valid,
                "R7 access", {mem_ce_n, 3'b0, mem_oe_n, 8'b0, mem_addr}, {~m, 12'h000, a});
            req_write = 1; req_addr = ~a;
        end
        req_valid = 0;
        @(negedge clk);
        chk(rd_valid && rd_data == exp, "R8 read data", rd_data, exp);
        if (m == 4'h0) chk(rd_data == 0, "R11 empty mask", rd_data, 0);
        chk(&mem_ce_n && mem_oe_n && !mem_dq_oe && !req_ready,
            "R9 turn", {mem_ce_n, 28'(req_ready)}, {4'hF, 28'd0});
        @(negedge clk);
        chk(!rd_valid && req_ready, "R8 pulse/R9 idle", {31'(rd_valid), req_ready}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin model[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        chk(&mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 in reset",
            {mem_ce_n, 28'(mem_we_n)}, {4'hF, 28'd1});
        rst = 0;
        @(negedge clk);
        chk(req_ready && !rd_valid && &mem_ce_n, "R1 after reset",
            {31'(rd_valid), req_ready}, 32'd1);
        // Full sweep of lane masks on four addresses.
        for (int a = 0; a < 4; a++) begin
            for (int m = 0; m < 16; m++) begin
                do_write(16'(a * 37 + 1), 32'h9E3779B9 * 32'(a * 16 + m + 1), 4'(m));
                do_read(16'(a * 37 + 1), 4'hF);
            end
        end
        // Mask-zero write must not disturb the word (R11).
        do_write(16'd1, 32'hDEADBEEF, 4'h0);
        do_read(16'd1, 4'hF);
        // Read back one word under every mask.
        for (int m = 0; m < 16; m++) do_read(16'd75, 4'(m));
        // Back-to-back requests held valid.
        do_write(16'd200, 32'h01234567, 4'hF);
        do_read(16'd200, 4'h5);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            errs++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule